// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles, producing one quotient bit per cycle. It keeps a single double-width shift register whose upper part accumulates the partial remainder while its lower part fills up with quotient bits from the right. A divisor register and one subtractor complete the datapath. The register is shifted left once at load. Each cycle, the divisor is subtracted from the upper part. A negative difference is discarded, which restores the old value, and the register shifts in a 0; otherwise the difference is kept and a 1 is shifted in. After the last step, the upper part read one bit to the right is the remainder.

A caller presents both operands and a mode bit together with a one-cycle start request. In signed mode the operands are reduced to magnitudes before the loop. The quotient is negated when the operand signs differ, and the remainder carries the sign of the dividend. The block performs no divide-by-zero trap and no overflow check; such inputs give whatever the loop produces. Results stay on the outputs until the next accepted start.

Top module: `seq_divider`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are low and `quotient` and `remainder` are zero.
- R2: A start request seen at a clock edge while the block is idle raises `busy` from that edge. `done` is high for exactly one cycle, which begins WIDTH clock edges after the accepting edge. `busy` is low while `done` is high.
- R3: With `signedMode` = 0, the outputs are the unsigned floor quotient and remainder, so quotient × divisor + remainder equals the dividend (mod 2^WIDTH) and remainder < divisor for every nonzero divisor. Example: 7 ÷ 2 gives 3 remainder 1.
- R4: With `signedMode` = 1, the quotient is truncated toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend. −7 ÷ 2 gives −3 remainder −1; −7 ÷ −2 gives 3 remainder −1; 7 ÷ −2 gives −3 remainder 1.
- R5: Once `done` has pulsed, `quotient` and `remainder` keep their values on every later cycle until another start is accepted.
- R6: A start request made while `busy` or `done` is high is ignored. The running division completes with results from its own operands, and no extra `done` pulse follows.
- R7: An unsigned division by zero yields a quotient of all ones and a remainder equal to the dividend.
- R8: In signed mode, the most negative dividend is handled as its full magnitude. It divided by −1 gives quotient 0x80000000 (the wrapped value) and remainder 0; it divided by 1 gives 0x80000000 remainder 0.
- R9: Unsigned divisors with the top bit set are divided correctly. 0xFFFFFFFF ÷ 0x80000001 gives 1 remainder 0x7FFFFFFE, and 0xFFFFFFFE ÷ 0xFFFFFFFF gives 0 remainder 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken only while idle |
| signedMode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Dividend, sampled on the accepting edge |
| divisor | input | WIDTH | Divisor, sampled on the accepting edge |
| busy | output | 1 | High while quotient bits are being formed |
| done | output | 1 | One-cycle pulse when results become valid |
| quotient | output | WIDTH | Quotient of the last accepted division |
| remainder | output | WIDTH | Remainder of the last accepted division |

## Verification
A new start request can land in the same cycle as an iteration step or as the completion pulse, and the block must give priority to the division already in flight. The bench provokes both cases. It drives start with different operands and the opposite mode midway through a run, and again in the very cycle `done` is seen. It then judges the outcome by the scoreboard entry of the original division, which must match. Any `done` pulse that arrives with no entry pending is counted as a failure, and after the late request the outputs must stay unchanged for longer than a full run.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, apply the initial left shift
    logic step;  // one subtract / restore / shift iteration
  } divCtrl_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  localparam int CntW = $clog2(WIDTH + 1);
  localparam logic [CntW-1:0] LastStep = CntW'(WIDTH - 1);

  divState_t state;
  logic [CntW-1:0] stepCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LastStep) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load = (state == ST_IDLE) && start;
    ctrl.step = (state == ST_RUN);
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_FIN);

  // R2: completion lasts a single cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: completion only follows a running division
  assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  // R2: step counter never passes the operand width while running
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt < CntW'(WIDTH)));

  // R6: a request during a run does not restart or stall it
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtrl_t         ctrl,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  // one guard bit above the upper part keeps 2*partial remainder exact
  localparam int RegW = 2 * WIDTH + 1;
  localparam int UpW  = WIDTH + 1;
  localparam int DifW = WIDTH + 2;

  logic [RegW-1:0]  remReg;
  logic [WIDTH-1:0] dvsReg;
  logic             negQ;
  logic             negR;

  logic             dvdNeg, dvsNeg;
  logic [WIDTH-1:0] absDvd, absDvs;
  logic [UpW-1:0]   upper;
  logic [DifW-1:0]  diff;
  logic             isNeg;
  logic [UpW-1:0]   keptUpper;
  logic [RegW-1:0]  stepNext;
  logic [WIDTH-1:0] magQ, magR;

  always_comb begin
    dvdNeg = signedMode & dividend[WIDTH-1];
    dvsNeg = signedMode & divisor[WIDTH-1];
    absDvd = dvdNeg ? (~dividend + 1'b1) : dividend;
    absDvs = dvsNeg ? (~divisor + 1'b1) : divisor;
  end

  always_comb begin
    upper     = remReg[RegW-1:WIDTH];
    diff      = {1'b0, upper} - {2'b00, dvsReg};
    isNeg     = diff[DifW-1];
    keptUpper = isNeg ? upper : diff[UpW-1:0];
    stepNext  = {keptUpper[UpW-2:0], remReg[WIDTH-1:0], ~isNeg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg <= '0;
      dvsReg <= '0;
      negQ   <= 1'b0;
      negR   <= 1'b0;
    end else if (ctrl.load) begin
      remReg <= {{WIDTH{1'b0}}, absDvd, 1'b0};
      dvsReg <= absDvs;
      negQ   <= dvdNeg ^ dvsNeg;
      negR   <= dvdNeg;
    end else if (ctrl.step) begin
      remReg <= stepNext;
    end
  end

  always_comb begin
    magQ      = remReg[WIDTH-1:0];
    magR      = remReg[RegW-1:WIDTH+1];
    quotient  = negQ ? (~magQ + 1'b1) : magQ;
    remainder = negR ? (~magR + 1'b1) : magR;
  end

  // R3: the partial remainder entering a step stays below twice the divisor
  assert_partial_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && (dvsReg != '0)) |-> (upper < {dvsReg, 1'b0}));

  // R2: the sequencer never loads and steps in the same cycle
  assert_strobe_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.load && ctrl.step));

  // R5: with no strobe the stored result does not move
  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.load && !ctrl.step) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             signedMode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divCtrl_t ctrl;

  div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  div_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .signedMode (signedMode),
    .dividend   (dividend),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder)
  );

  // R2: busy and done never overlap
  assert_busy_done_apart_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

endmodule

// File: tb/seq_divider_tb.sv
`timescale 1ns/1ps
module seq_divider_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         signedMode = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  always #2.5 clk = ~clk;

  seq_divider #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  typedef struct {
    logic [W-1:0] expQ;
    logic [W-1:0] expR;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         sgn;
    int           startEdge;
    string        tag;
  } item_t;

  item_t sb[$];
  int nRun = 0;
  int nFail = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                input logic sgn,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    longint sa, sb2;
    if (b == '0) begin
      q = '1;
      r = a;
    end else if (sgn) begin
      sa  = longint'($signed(a));
      sb2 = longint'($signed(b));
      q = W'(sa / sb2);
      r = W'(sa % sb2);
    end else begin
      sa  = longint'({32'b0, a});
      sb2 = longint'({32'b0, b});
      q = W'(sa / sb2);
      r = W'(sa % sb2);
    end
  endfunction

  // monitor: pops one expected entry per completion pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sb.size() == 0) begin
        nRun++;
        nFail++;
        $display("FAIL R6 unexpected done actual=1 expected=0");
      end else begin
        item_t it;
        longint absR, absB, rs, bs;
        logic [W-1:0] recon;
        it = sb.pop_front();
        check(quotient == it.expQ, {it.tag, " quotient"}, quotient, it.expQ);
        check(remainder == it.expR, {it.tag, " remainder"}, remainder, it.expR);
        check((cyc - it.startEdge) == W, "R2 done latency",
              W'(cyc - it.startEdge), W'(W));
        check(!busy, "R2 busy low at done", W'(busy), '0);
        if (it.b != '0) begin
          recon = W'(quotient * it.b + remainder);
          check(recon == it.a, {it.tag, " identity"}, recon, it.a);
          if (it.sgn) begin
            rs = longint'($signed(remainder));
            bs = longint'($signed(it.b));
            absR = (rs < 0) ? -rs : rs;
            absB = (bs < 0) ? -bs : bs;
          end else begin
            absR = longint'({32'b0, remainder});
            absB = longint'({32'b0, it.b});
          end
          check(absR < absB, {it.tag, " remainder bound"}, remainder, it.b);
        end
      end
    end
  end

  // pokeMode: 0 none, 1 request midway through the run, 2 request in the done cycle
  task automatic doDiv(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sgn, input string tag, input int pokeMode);
    item_t it;
    logic [W-1:0] q, r;
    @(negedge clk);
    while (busy || done) @(negedge clk);
    model(a, b, sgn, q, r);
    it.expQ = q; it.expR = r; it.a = a; it.b = b; it.sgn = sgn;
    it.startEdge = cyc + 1; it.tag = tag;
    sb.push_back(it);
    dividend = a; divisor = b; signedMode = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", W'(busy), W'(1));
    if (pokeMode == 1) begin
      repeat (5) @(negedge clk);
      dividend = ~a; divisor = b + 1; signedMode = ~sgn; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (pokeMode == 2) begin
      dividend = a + 3; divisor = 5; signedMode = ~sgn; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (W + 5) @(negedge clk);
      check(!busy, "R6 no restart from done-cycle request", W'(busy), '0);
      check(quotient == q, "R6 quotient kept", quotient, q);
      check(remainder == r, "R6 remainder kept", remainder, r);
    end else begin
      repeat (3) @(negedge clk);
      check(quotient == q, "R5 quotient held", quotient, q);
      check(remainder == r, "R5 remainder held", remainder, r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 flags in reset", {30'b0, busy, done}, '0);
    check(quotient == '0, "R1 quotient in reset", quotient, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(remainder == '0, "R1 remainder after reset", remainder, '0);
    check(!busy && !done, "R1 flags after reset", {30'b0, busy, done}, '0);

    doDiv(32'd7, 32'd2, 1'b0, "R3", 0);
    doDiv(32'd1000, 32'd10, 1'b0, "R3", 0);
    doDiv(32'hFFFF_FFFF, 32'd1, 1'b0, "R3", 0);
    doDiv(32'd5, 32'd9, 1'b0, "R3", 0);

    doDiv(-32'sd7, 32'sd2, 1'b1, "R4", 0);
    doDiv(-32'sd7, -32'sd2, 1'b1, "R4", 0);
    doDiv(32'sd7, -32'sd2, 1'b1, "R4", 0);

    doDiv(32'd12345, 32'd0, 1'b0, "R7", 0);

    doDiv(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R8", 0);
    doDiv(32'h8000_0000, 32'd1, 1'b1, "R8", 0);

    doDiv(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R9", 0);
    doDiv(32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, "R9", 0);

    doDiv(32'd100, 32'd7, 1'b0, "R6", 1);
    doDiv(-32'sd100, 32'sd7, 1'b1, "R6", 2);

    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom >> ($urandom % 32);
      if (rb == '0) rb = 32'd1;
      doDiv(ra, rb, 1'b0, "R3", 0);
    end
    for (int i = 0; i < 30; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = W'($signed($urandom) >>> ($urandom % 32));
      if (rb == '0) rb = 32'd3;
      doDiv(ra, rb, 1'b1, "R4", 0);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R2 all results delivered", W'(sb.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule